// File: doc/BRIEF.md
# One-Hot Control Sequencer with Terminal-State Recovery

This block steps a single active token through a linear chain of control states, one flip-flop per state. Each non-terminal state owns an advance input. When that input is high, the token moves to the next state on the next clock. When it is low, the token stays where it is. The last state lasts one clock, raises a done strobe and hands the token back to the first state. The block is fully synchronous and is meant to sequence a datapath where each state flop must stay shallow.

The state register is built to survive upsets, such as a particle strike that flips a flop, without decoding every illegal code. The terminal state reloads the whole register with the start code, so any stray extra bits are flushed when the leading bit gets there. An empty register reloads the start code on the next clock. An optional idle scrub clears every other bit when the start bit is found sharing the register with them. An `upset_i` vector XORs into the register update, so an environment can model strikes.

Top module: `onehot_recover_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads the start code (only bit 0 set), whatever `upset_i` holds.
- R2: Bit i stands for state i. From a legal state i below the terminal, `adv_i[i]=1` moves the token to bit i+1 on the next clock, and `adv_i[i]=0` keeps it at bit i. With several bits set and no recovery condition, each bit follows its own advance input, and bits that land together merge.
- R3: The terminal state (bit NUM_STATES-1) is held for exactly one clock and is followed by the start code, whatever the advance inputs are.
- R4: `done_o` equals the terminal bit of the register, so it pulses for one clock per pass.
- R5: If the terminal bit is set together with any other bits, the next register value is the start code.
- R6: An all-zero register becomes the start code on the next clock.
- R7: With IDLE_SCRUB=1, a register holding bit 0 and any other bit (terminal bit clear) becomes the start code on the next clock, with no advance that clock.
- R8: Outside reset, the value loaded into the register is the next-state value XOR `upset_i`, so bit i of `upset_i` flips bit i.
- R9: With `upset_i` zero and all advance inputs high, any register value becomes exactly one-hot within NUM_STATES-1 clocks. A one-hot register stays one-hot while `upset_i` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | NUM_STATES-1 | Advance condition for each non-terminal state |
| upset_i | input | NUM_STATES | Bit flips XORed into the register update |
| state_o | output | NUM_STATES | One-hot state vector |
| done_o | output | 1 | High while the terminal state is active |

## Verification
The bench drives the register into chosen illegal codes through `upset_i` and then checks the recovery path for each one. It covers terminal-plus-stray bits, the empty code, start-plus-stray bits, and multi-hot codes that only shift. A design that skipped the terminal flush would keep carrying ghost tokens. A design missing the empty check would lock up with every bit clear. A scrub that still let the start bit advance would turn up one state early. Random upsets followed by free running check that the register is one-hot again within NUM_STATES-1 clocks. They also check that a terminal state lasting two clocks, or a done strobe out of step with the terminal bit, is caught on every step.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Why the register is being reloaded with the start code this cycle.
  typedef enum logic [1:0] {
    RC_NONE     = 2'd0,
    RC_TERMINAL = 2'd1,
    RC_EMPTY    = 2'd2,
    RC_SCRUB    = 2'd3
  } recover_e;
endpackage

// File: rtl/seq_step.sv
module seq_step #(
  parameter int NUM_STATES = 8
) (
  input  logic [NUM_STATES-1:0] q,
  input  logic [NUM_STATES-2:0] adv,
  output logic [NUM_STATES-1:0] nxt
);
  localparam int LAST = NUM_STATES - 1;

  // Each flop sees only its own bit, its predecessor and two advance terms.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STATES; gi++) begin : g_bit
      if (gi == 0) begin : g_first
        assign nxt[gi] = q[gi] & ~adv[gi];
      end else if (gi == LAST) begin : g_last
        assign nxt[gi] = q[gi-1] & adv[gi-1];
      end else begin : g_mid
        assign nxt[gi] = (q[gi] & ~adv[gi]) | (q[gi-1] & adv[gi-1]);
      end
    end
  endgenerate
endmodule

// File: rtl/seq_guard.sv
module seq_guard
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter bit IDLE_SCRUB = 1'b1
) (
  input  logic [NUM_STATES-1:0] q,
  output logic                  term_hit,
  output logic                  empty_hit,
  output logic                  scrub_hit,
  output recover_e              cause
);
  localparam int LAST = NUM_STATES - 1;

  assign term_hit  = q[LAST];
  assign empty_hit = ~|q;

  generate
    if (IDLE_SCRUB) begin : g_scrub
      assign scrub_hit = q[0] & (|q[LAST:1]);
    end else begin : g_noscrub
      assign scrub_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (term_hit)       cause = RC_TERMINAL;
    else if (empty_hit) cause = RC_EMPTY;
    else if (scrub_hit) cause = RC_SCRUB;
    else                cause = RC_NONE;
  end
endmodule

// File: rtl/onehot_recover_seq.sv
module onehot_recover_seq
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter bit IDLE_SCRUB = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STATES-2:0] adv_i,
  input  logic [NUM_STATES-1:0] upset_i,
  output logic [NUM_STATES-1:0] state_o,
  output logic                  done_o
);
  localparam int LAST = NUM_STATES - 1;
  localparam logic [NUM_STATES-1:0] START = {{(NUM_STATES-1){1'b0}}, 1'b1};

  logic [NUM_STATES-1:0] q;
  logic [NUM_STATES-1:0] step_nxt;
  logic [NUM_STATES-1:0] next_q;
  logic                  term_hit, empty_hit, scrub_hit;
  recover_e              cause;

  seq_step #(.NUM_STATES(NUM_STATES)) u_step (
    .q   (q),
    .adv (adv_i),
    .nxt (step_nxt)
  );

  seq_guard #(.NUM_STATES(NUM_STATES), .IDLE_SCRUB(IDLE_SCRUB)) u_guard (
    .q         (q),
    .term_hit  (term_hit),
    .empty_hit (empty_hit),
    .scrub_hit (scrub_hit),
    .cause     (cause)
  );

  assign next_q = (cause != RC_NONE) ? START : step_nxt;

  always_ff @(posedge clk) begin
    if (rst) q <= START;
    else     q <= next_q ^ upset_i;
  end

  assign state_o = q;
  assign done_o  = q[LAST];

  AST_RESET_START: assert property (@(posedge clk)
    rst |=> state_o == START); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (upset_i == '0 && $countones(state_o) == 1 && !state_o[LAST] &&
     (adv_i & state_o[LAST-1:0]) != '0) |=> state_o == ($past(state_o) << 1)); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upset_i == '0 && $countones(state_o) == 1 && !state_o[LAST] &&
     (adv_i & state_o[LAST-1:0]) == '0) |=> $stable(state_o)); // R2

  AST_TERM_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (term_hit && upset_i == '0) |=> state_o == START); // R3 R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done_o && upset_i == '0) |=> !done_o); // R4

  AST_EMPTY_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (empty_hit && upset_i == '0) |=> state_o == START); // R6

  AST_SCRUB: assert property (@(posedge clk) disable iff (rst)
    (scrub_hit && upset_i == '0) |=> state_o == START); // R7

  AST_ONEHOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_o) == 1 && upset_i == '0) |=> $countones(state_o) == 1); // R9
endmodule

// File: tb/onehot_recover_seq_bench.sv
module onehot_recover_seq_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-2:0] adv;
  logic [N-1:0] upset;
  logic [N-1:0] state_o;
  logic         done_o;
  logic [N-1:0] exp_q;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  onehot_recover_seq #(.NUM_STATES(N), .IDLE_SCRUB(1'b1)) u_onehot_recover_seq (
    .clk(clk), .rst(rst), .adv_i(adv), .upset_i(upset),
    .state_o(state_o), .done_o(done_o)
  );

  // Entry: {starting register, advance inputs, expected next register}
  localparam logic [22:0] VEC [12] = '{
    {8'b00000001, 7'b0000001, 8'b00000010},
    {8'b00000001, 7'b0000000, 8'b00000001},
    {8'b00001000, 7'b0001000, 8'b00010000},
    {8'b01000000, 7'b1000000, 8'b10000000},
    {8'b10000000, 7'b0000000, 8'b00000001},
    {8'b10000000, 7'b1111111, 8'b00000001},
    {8'b10010100, 7'b1111111, 8'b00000001},
    {8'b00000000, 7'b1010101, 8'b00000001},
    {8'b00000101, 7'b1111111, 8'b00000001},
    {8'b00010100, 7'b0010100, 8'b00101000},
    {8'b00001100, 7'b0000100, 8'b00001000},
    {8'b01000010, 7'b0000000, 8'b01000010}
  };
  string vtag [12] = '{"R2", "R2", "R2", "R2", "R3", "R3",
                       "R5", "R6", "R7", "R2", "R2", "R2"};

  // Independent next-state model, written bit by bit.
  function automatic logic [N-1:0] model(input logic [N-1:0] q, input logic [N-2:0] a);
    logic [N-1:0] r;
    int ones;
    r = '0;
    ones = 0;
    for (int i = 0; i < N; i++) if (q[i]) ones++;
    if (q[N-1] || ones == 0 || (q[0] && ones > 1)) return 8'b00000001;
    for (int i = 0; i < N - 1; i++) begin
      if (q[i]) begin
        if (a[i]) r[i+1] = 1'b1;
        else      r[i]   = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // Called just after a falling edge; drives inputs, waits one cycle, compares.
  task automatic step(input bit r, input logic [N-2:0] a, input logic [N-1:0] u,
                      input string tag);
    rst = r; adv = a; upset = u;
    exp_q = r ? 8'b00000001 : (model(exp_q, a) ^ u);
    @(negedge clk);
    chk(state_o == exp_q, tag, state_o, exp_q);
    chk(done_o == exp_q[N-1], "R4", {7'b0, done_o}, {7'b0, exp_q[N-1]});
  endtask

  task automatic load(input logic [N-1:0] target);
    step(1'b0, '0, model(exp_q, '0) ^ target, "R8");
  endtask

  initial begin
    rst = 1'b1; adv = '0; upset = '0; exp_q = 8'b00000001;
    @(negedge clk);
    // R1: reset wins over a simultaneous upset
    step(1'b1, 7'h7f, 8'hA5, "R1");
    step(1'b1, 7'h00, 8'h00, "R1");

    // Table walk
    for (int k = 0; k < 12; k++) begin
      load(VEC[k][22:15]);
      step(1'b0, VEC[k][14:8], '0, vtag[k]);
      chk(state_o == VEC[k][7:0], vtag[k], state_o, VEC[k][7:0]);
    end

    // R4 / R3: full pass, done high exactly once
    begin
      int pulses;
      pulses = 0;
      step(1'b1, '0, '0, "R1");
      for (int c = 0; c < 2 * N; c++) begin
        step(1'b0, 7'h7f, '0, "R3");
        if (done_o) pulses++;
      end
      chk(pulses == 2, "R4", pulses[N-1:0], 8'd2);
    end

    // R8: upsets on a running machine
    for (int k = 0; k < 10; k++)
      step(1'b0, 7'($urandom), 8'($urandom) & 8'($urandom), "R8");

    // R9: random illegal codes recover within N-1 clocks under free running
    for (int t = 0; t < 40; t++) begin
      load(8'($urandom));
      for (int c = 0; c < N - 1; c++) step(1'b0, 7'h7f, '0, "R9");
      chk($countones(state_o) == 1, "R9", state_o, exp_q);
      for (int c = 0; c < 3; c++) begin
        step(1'b0, 7'($urandom), '0, "R9");
        chk($countones(state_o) == 1, "R9", state_o, exp_q);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule